// File: doc/BRIEF.md
# Downstream I/O Window Decoder

This block sits on the downstream I/O path of a bridge. Every I/O request that arrives from the upstream link passes through it. For each request the block gives one of two results: send the request on to the secondary bus, or answer it with a master-abort completion. The decision depends on two things. The first is an I/O enable flag held in a command register. The second is a single address window, bounded by a programmable base and a programmable limit.

The window has a 4 KB granule. The base marks the first byte of its granule and the limit marks the last byte of its granule. Upper registers widen both bounds to the full 32-bit I/O address. If the programmed base is above the programmed limit, the window is off. Software programs the registers through a simple write port. The new values apply to requests from the following clock on.

Requests come as a valid strobe with an address. The block takes one request per clock and never applies back-pressure, so the request side has no ready signal. The result comes out as two registered strobes, forward and abort, one clock after the request.

Top module: `io_window_decode`

## Requirements
- R1: After reset the I/O enable flag is clear. The base is all ones in every field and the limit is all zeros, so the window is off. A request after reset, even with only the enable flag set afterwards, gets abort.
- R2: A request with `req_valid` high in cycle N gives exactly one of `fwd_o` or `abort_o` high in cycle N+1. Without a request, both strobes stay low in N+1.
- R3: While the enable flag (command write, `cfg_wdata[0]`, `cfg_sel`=0) is clear, every request is aborted.
- R4: With the flag set and the window on, an address with base <= address <= limit is forwarded. Both bounds are inclusive.
- R5: With the flag set, an address below the base or above the limit is aborted.
- R6: When the full 32-bit base is greater than the full 32-bit limit, no request is forwarded, even with the flag set.
- R7: `cfg_sel`=1 writes `cfg_wdata[3:0]` as base address bits [15:12]; base bits [11:0] are 000h. `cfg_sel`=2 writes `cfg_wdata[3:0]` as limit bits [15:12]; limit bits [11:0] are FFFh.
- R8: `cfg_sel`=3 writes `cfg_wdata[15:0]` as base bits [31:16]. `cfg_sel`=4 writes `cfg_wdata[15:0]` as limit bits [31:16]. Both the window test and the off test use the full 32-bit values.
- R9: A request in the same cycle as a configuration write is decided with the old register values. Requests from the next cycle on use the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An I/O request is present this cycle |
| req_addr | input | 32 | I/O address of the request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select: 0 command, 1 base low, 2 limit low, 3 base high, 4 limit high |
| cfg_wdata | input | 16 | Configuration write data |
| fwd_o | output | 1 | Forward result for the request of the previous cycle |
| abort_o | output | 1 | Master-abort result for the request of the previous cycle |

## Verification
The assertions check on every cycle that:
- the two result strobes never rise together;
- a result appears exactly one cycle after each request and at no other time;
- a forward only follows a cycle in which the enable flag was set, the window was on and the address lay within the bounds.

The assertions cannot tell whether the bounds were built correctly from the register fields, or whether a same-cycle write was ignored for the request beside it. Only the bench shows those. It sweeps all low base/limit field pairs against granule edges, walks the upper-field combinations, and runs the write/request collision.

// File: rtl/io_window_pkg.sv
package io_window_pkg;
  typedef enum logic [2:0] {
    SEL_CMD     = 3'd0,
    SEL_BASE_LO = 3'd1,
    SEL_LIM_LO  = 3'd2,
    SEL_BASE_HI = 3'd3,
    SEL_LIM_HI  = 3'd4
  } cfg_sel_e;
endpackage

// File: rtl/io_window_regs.sv
module io_window_regs
  import io_window_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 12,
  parameter int SPLIT  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              io_en,
  output logic [ADDR_W-1:0] win_base,
  output logic [ADDR_W-1:0] win_limit
);
  localparam int LO_W = SPLIT - GRAN_W;
  localparam int HI_W = ADDR_W - SPLIT;

  logic [LO_W-1:0] base_lo, lim_lo;
  logic [HI_W-1:0] base_hi, lim_hi;
  cfg_sel_e        sel;

  assign sel = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      io_en   <= 1'b0;
      base_lo <= '1;
      base_hi <= '1;
      lim_lo  <= '0;
      lim_hi  <= '0;
    end else if (cfg_we) begin
      case (sel)
        SEL_CMD:     io_en   <= cfg_wdata[0];
        SEL_BASE_LO: base_lo <= cfg_wdata[LO_W-1:0];
        SEL_LIM_LO:  lim_lo  <= cfg_wdata[LO_W-1:0];
        SEL_BASE_HI: base_hi <= cfg_wdata[HI_W-1:0];
        SEL_LIM_HI:  lim_hi  <= cfg_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  assign win_base  = {base_hi, base_lo, {GRAN_W{1'b0}}};
  assign win_limit = {lim_hi, lim_lo, {GRAN_W{1'b1}}};

  // R9: register state only moves on a write strobe
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_we) |-> ($stable(io_en) && $stable(win_base) && $stable(win_limit)));
  // R7: the granule bits of the bounds are fixed
  a_r7_granule_edges: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base[GRAN_W-1:0] == '0) && (win_limit[GRAN_W-1:0] == '1));
endmodule

// File: rtl/io_window_match.sv
module io_window_match #(
  parameter int ADDR_W = 32
) (
  input  logic              io_en,
  input  logic [ADDR_W-1:0] win_base,
  input  logic [ADDR_W-1:0] win_limit,
  input  logic [ADDR_W-1:0] addr,
  output logic              win_on,
  output logic              hit
);
  logic above_base, below_limit;

  always_comb begin
    win_on      = (win_base <= win_limit);
    above_base  = (addr >= win_base);
    below_limit = (addr <= win_limit);
    hit         = io_en && win_on && above_base && below_limit;
  end
endmodule

// File: rtl/io_window_decode.sv
module io_window_decode #(
  parameter int ADDR_W = 32,
  parameter int GRAN_W = 12,
  parameter int SPLIT  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              fwd_o,
  output logic              abort_o
);
  logic              io_en, win_on, hit;
  logic [ADDR_W-1:0] win_base, win_limit;

  io_window_regs #(
    .ADDR_W(ADDR_W), .GRAN_W(GRAN_W), .SPLIT(SPLIT), .DATA_W(DATA_W)
  ) i_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .io_en(io_en), .win_base(win_base), .win_limit(win_limit)
  );

  io_window_match #(.ADDR_W(ADDR_W)) i_match (
    .io_en(io_en), .win_base(win_base), .win_limit(win_limit),
    .addr(req_addr), .win_on(win_on), .hit(hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_o   <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      fwd_o   <= req_valid && hit;
      abort_o <= req_valid && !hit;
    end
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_o && abort_o));
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (fwd_o || abort_o));
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(fwd_o || abort_o));
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> $past(io_en));
  a_r6_needs_window_on: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> $past(win_base <= win_limit));
  a_r4_inside_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_o |-> ($past(req_addr >= win_base) && $past(req_addr <= win_limit)));
endmodule

// File: tb/test_io_window_decode.sv
module test_io_window_decode;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        fwd_o, abort_o;

  int n_vec = 0;
  int n_bad = 0;
  logic        m_en;
  logic [31:0] m_base, m_lim;

  always #5 clk = ~clk;

  io_window_decode i_io_window_decode (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .fwd_o(fwd_o), .abort_o(abort_o)
  );

  task automatic check(input logic ef, input logic ea, input string tag);
    n_vec++;
    if (fwd_o !== ef || abort_o !== ea) begin
      n_bad++;
      $display("FAIL %s addr=%h got fwd=%b abort=%b exp fwd=%b abort=%b",
               tag, req_addr, fwd_o, abort_o, ef, ea);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic model(input logic [31:0] a);
    return m_en && (m_base <= m_lim) && (a >= m_base) && (a <= m_lim);
  endfunction

  task automatic probe(input logic [31:0] a, input string tag);
    logic e;
    e = model(a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(e, !e, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b0, 1'b0, "R1 reset strobes");
    m_en = 1'b0; m_base = 32'hFFFF_F000; m_lim = 32'h0000_0FFF;
    probe(32'h0000_0000, "R1/R3 after reset");
    wr(3'd0, 16'h0001); m_en = 1'b1;
    probe(32'h0000_0800, "R1 window off after reset");
    probe(32'hFFFF_FFFF, "R1 window off after reset");
    // idle cycle: no result
    @(negedge clk);
    check(1'b0, 1'b0, "R2 no request no strobe");
    // exhaustive sweep of low fields, upper fields zero
    wr(3'd3, 16'h0000); wr(3'd4, 16'h0000);
    for (int b = 0; b < 16; b++) begin
      for (int l = 0; l < 16; l++) begin
        wr(3'd1, 16'(b)); wr(3'd2, 16'(l));
        m_base = {16'h0, 4'(b), 12'h000};
        m_lim  = {16'h0, 4'(l), 12'hFFF};
        for (int k = 0; k < 16; k++) begin
          probe({16'h0, 4'(k), 12'h000}, "R4/R5/R6/R7 low sweep");
          probe({16'h0, 4'(k), 12'hFFF}, "R4/R5/R6/R7 low sweep");
        end
      end
    end
    // upper fields
    for (int bh = 0; bh < 3; bh++) begin
      for (int lh = 0; lh < 3; lh++) begin
        wr(3'd1, 16'h8); wr(3'd2, 16'h3);
        wr(3'd3, 16'(bh)); wr(3'd4, 16'(lh));
        m_base = {16'(bh), 4'h8, 12'h000};
        m_lim  = {16'(lh), 4'h3, 12'hFFF};
        for (int h = 0; h < 4; h++) begin
          for (int k = 0; k < 16; k++) begin
            probe({16'(h), 4'(k), 12'h000}, "R8 upper sweep");
            probe({16'(h), 4'(k), 12'hFFF}, "R8 upper sweep");
          end
        end
      end
    end
    // enable off with a wide window
    wr(3'd3, 16'h0000); wr(3'd4, 16'hFFFF);
    wr(3'd1, 16'h0); wr(3'd2, 16'hF);
    m_base = 32'h0; m_lim = 32'hFFFF_FFFF;
    wr(3'd0, 16'h0000); m_en = 1'b0;
    for (int k = 0; k < 16; k++) probe({k[3:0], 28'h0}, "R3 enable clear");
    // R9: same-cycle write uses old value
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd0; cfg_wdata = 16'h0001;
    req_valid = 1'b1; req_addr = 32'h0000_1234;
    @(negedge clk);
    cfg_we = 1'b0;
    check(1'b0, 1'b1, "R9 same cycle old enable");
    @(negedge clk);
    req_valid = 1'b0;
    check(1'b1, 1'b0, "R9 next cycle new enable");
    // R9 on the limit register
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'd4; cfg_wdata = 16'h0000;
    req_valid = 1'b1; req_addr = 32'h0001_0000;
    @(negedge clk);
    cfg_we = 1'b0;
    check(1'b1, 1'b0, "R9 same cycle old limit");
    @(negedge clk);
    req_valid = 1'b0;
    check(1'b0, 1'b1, "R9 next cycle new limit");
    @(negedge clk);
    check(1'b0, 1'b0, "R2 idle after burst");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule